// File: doc/BRIEF.md
# External Reset Pulse Generator

This block turns a watchdog expiry event into a timed pulse on an external reset pin. The pulse width, its polarity and the pin's drive type all come from a single 32-bit configuration word. A 1 MHz tick input sets the time base, so one width unit is one microsecond. A pulse lasts the programmed width plus one tick. The watchdog's external-signal enable gates whether an expiry starts a pulse at all.

The width field sits in bits 19:0 and is rewritten by every configuration write. Polarity and drive type are two state bits. Software cannot write them directly. A key value in bits 31:24 of a write changes them, and any other top-byte value leaves them as they are. They read back at bits 31 and 30. The pin is modelled as a data bit plus an output enable, which lets open-drain behaviour be shown without a pad cell.

The timer is a two-state machine with states IDLE and PULSE:
- **IDLE to PULSE** happens on a gated expiry.
- **PULSE to PULSE with reload** happens on a gated expiry during the pulse.
- **PULSE counting down** happens on each tick while the count is not zero.
- **PULSE to IDLE** happens on a tick with the count at zero.

Top module: `ext_rst_pulse`

## Requirements
- R1: After reset the readback is 0x000000FF (width 0xFF, active-low, open-drain), no pulse is active, `pin_oe` is 0 and `pin_o` is 1.
- R2: Every write to the configuration word loads the width field from `cfg_wdata[19:0]`, and the new value is visible on `cfg_rdata[19:0]` in the cycle after the write.
- R3: A write with top byte 0xA5 selects active-high polarity and 0x5A selects active-low. Polarity reads back on `cfg_rdata[31]` (1 means active-high).
- R4: A write with top byte 0xA8 selects push-pull drive and 0x8A selects open-drain. Drive type reads back on `cfg_rdata[30]` (1 means push-pull).
- R5: A write with any other top-byte value leaves polarity and drive type unchanged.
- R6: Bits 29:20 of `cfg_rdata` always read 0, whatever was written there.
- R7: When `expire` is high in a cycle with `ext_en` high, a pulse begins and `pulse_active` is 1 from the next cycle. When `ext_en` is low, `expire` has no effect.
- R8: A pulse started with width value W ends on the (W+1)-th tick that follows the start. A width of 0 gives a pulse of one tick.
- R9: A gated expiry during an active pulse reloads the count from the width field, so the pulse then lasts a further W+1 ticks.
- R10: In push-pull mode `pin_oe` is always 1. `pin_o` is at the active level during a pulse and at the opposite level otherwise.
- R11: In open-drain mode `pin_oe` is 1 only during a pulse, and `pin_o` is then at the active level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_us | input | 1 | One-cycle strobe at 1 MHz |
| expire | input | 1 | Watchdog expiry event |
| ext_en | input | 1 | External-signal enable from the watchdog control |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration readback |
| pin_o | output | 1 | Reset pin data value |
| pin_oe | output | 1 | Reset pin output enable |
| pulse_active | output | 1 | High while a pulse is in progress |

## Verification
Each result is due exactly one clock after its cause:
- a configuration write shows on `cfg_rdata` one clock after `cfg_we`;
- a gated expiry raises `pulse_active` and changes `pin_o` and `pin_oe` one clock later;
- the terminating tick drops the pulse one clock after it is sampled.

The bench drives each stimulus just after a rising edge. It then waits one rising edge and samples one time unit after it, so every check lands in the cycle where the result is due. Pulse length is checked by counting ticks: the pin must still be active after the W-th tick and inactive after the (W+1)-th.

// File: rtl/ext_rst_pulse_pkg.sv
package ext_rst_pulse_pkg;
    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_PULSE = 1'b1
    } pulse_state_e;

    localparam logic [7:0] KEY_POL_HIGH  = 8'hA5;
    localparam logic [7:0] KEY_POL_LOW   = 8'h5A;
    localparam logic [7:0] KEY_DRV_PUSH  = 8'hA8;
    localparam logic [7:0] KEY_DRV_OPEN  = 8'h8A;
endpackage

// File: rtl/ext_rst_pulse_cfg.sv
module ext_rst_pulse_cfg
    import ext_rst_pulse_pkg::*;
#(
    parameter int          WIDTH_W   = 20,
    parameter logic [19:0] WIDTH_RST = 20'h000FF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [31:0]        wdata,
    output logic [31:0]        rdata,
    output logic [WIDTH_W-1:0] width,
    output logic               act_high,
    output logic               push_pull
);
    localparam int PAD_W = 30 - WIDTH_W;

    logic [7:0] key;
    assign key = wdata[31:24];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            width     <= WIDTH_RST[WIDTH_W-1:0];
            act_high  <= 1'b0;
            push_pull <= 1'b0;
        end else if (we) begin
            width <= wdata[WIDTH_W-1:0];
            unique case (key)
                KEY_POL_HIGH: act_high  <= 1'b1;
                KEY_POL_LOW:  act_high  <= 1'b0;
                KEY_DRV_PUSH: push_pull <= 1'b1;
                KEY_DRV_OPEN: push_pull <= 1'b0;
                default: ;
            endcase
        end
    end

    assign rdata = {act_high, push_pull, {PAD_W{1'b0}}, width};

    // R5
    key_other_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && key != KEY_POL_HIGH && key != KEY_POL_LOW &&
         key != KEY_DRV_PUSH && key != KEY_DRV_OPEN)
        |=> ($stable(act_high) && $stable(push_pull)));

    // R3
    key_pol_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && key == KEY_POL_HIGH) |=> rdata[31]);

    // R2
    width_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (rdata[WIDTH_W-1:0] == $past(wdata[WIDTH_W-1:0])));
endmodule

// File: rtl/ext_rst_pulse_timer.sv
module ext_rst_pulse_timer
    import ext_rst_pulse_pkg::*;
#(
    parameter int WIDTH_W = 20
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic               start,
    input  logic [WIDTH_W-1:0] width,
    output logic               active
);
    pulse_state_e       state_q, state_d;
    logic [WIDTH_W-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d = ST_PULSE;
                    cnt_d   = width;
                end
            end
            ST_PULSE: begin
                if (start) begin
                    cnt_d = width;
                end else if (tick) begin
                    if (cnt_q == '0) state_d = ST_IDLE;
                    else             cnt_d   = cnt_q - 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        active = (state_q == ST_PULSE);
    end

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !start) |=> (state_q == ST_IDLE));

    // R9
    reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (state_q == ST_PULSE && cnt_q == $past(width)));

    // R8
    count_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PULSE && tick && !start && cnt_q != '0)
        |=> (cnt_q == $past(cnt_q) - 1'b1 && state_q == ST_PULSE));
endmodule

// File: rtl/ext_rst_pulse_enc.sv
module ext_rst_pulse_enc (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic act_high,
    input  logic push_pull,
    output logic pin_o,
    output logic pin_oe
);
    always_comb begin
        pin_o  = active ? act_high : ~act_high;
        pin_oe = push_pull | active;
    end

    // R10
    pp_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push_pull |-> pin_oe);

    // R11
    od_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!push_pull && !active) |-> !pin_oe);
endmodule

// File: rtl/ext_rst_pulse.sv
module ext_rst_pulse
    import ext_rst_pulse_pkg::*;
#(
    parameter int          WIDTH_W   = 20,
    parameter logic [19:0] WIDTH_RST = 20'h000FF
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick_us,
    input  logic        expire,
    input  logic        ext_en,
    input  logic        cfg_we,
    input  logic [31:0] cfg_wdata,
    output logic [31:0] cfg_rdata,
    output logic        pin_o,
    output logic        pin_oe,
    output logic        pulse_active
);
    logic [WIDTH_W-1:0] width;
    logic               act_high;
    logic               push_pull;
    logic               start;

    assign start = expire & ext_en;

    ext_rst_pulse_cfg #(.WIDTH_W(WIDTH_W), .WIDTH_RST(WIDTH_RST)) cfg_i (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata),
        .rdata(cfg_rdata), .width(width), .act_high(act_high),
        .push_pull(push_pull)
    );

    ext_rst_pulse_timer #(.WIDTH_W(WIDTH_W)) timer_i (
        .clk(clk), .rst_n(rst_n), .tick(tick_us), .start(start),
        .width(width), .active(pulse_active)
    );

    ext_rst_pulse_enc enc_i (
        .clk(clk), .rst_n(rst_n), .active(pulse_active),
        .act_high(act_high), .push_pull(push_pull),
        .pin_o(pin_o), .pin_oe(pin_oe)
    );

    // R6
    pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rdata[29:20] == 10'd0);
endmodule

// File: tb/ext_rst_pulse_tb_top.sv
module ext_rst_pulse_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_us = 1'b0, expire = 1'b0, ext_en = 1'b0, cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        pin_o, pin_oe, pulse_active;
    int          checks = 0, errors = 0;

    always #2.5 clk = ~clk;

    ext_rst_pulse dut_i (
        .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .expire(expire),
        .ext_en(ext_en), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .pin_o(pin_o), .pin_oe(pin_oe),
        .pulse_active(pulse_active)
    );

    // {write data, expected readback}
    localparam logic [63:0] VEC [10] = '{
        {32'h00000005, 32'h00000005},
        {32'hA5000010, 32'h80000010},
        {32'hA8000020, 32'hC0000020},
        {32'h5A000030, 32'h40000030},
        {32'h8A0FFFFF, 32'h000FFFFF},
        {32'hFFF00007, 32'h00000007},
        {32'hA5A00001, 32'h80000001},
        {32'h12345678, 32'h80045678},
        {32'hA8000000, 32'hC0000000},
        {32'h55000003, 32'hC0000003}
    };

    task automatic step();
        @(posedge clk);
        #1;
        tick_us = 1'b0; expire = 1'b0; cfg_we = 1'b0;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] d);
        cfg_we = 1'b1; cfg_wdata = d; step();
    endtask

    task automatic fire();
        expire = 1'b1; step();
    endtask

    task automatic tick();
        tick_us = 1'b1; step();
    endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog expired actual 0 expected 1");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        step();
        // R1
        chk("R1 readback", cfg_rdata, 32'h000000FF);
        chk("R1 idle oe/pin/act", {29'd0, pin_oe, pin_o, pulse_active}, 32'h2);

        // R2 R3 R4 R5 R6 vector walk
        for (int i = 0; i < 10; i++) begin
            wr(VEC[i][63:32]);
            chk($sformatf("R2/R3/R4/R5/R6 vector %0d", i), cfg_rdata, VEC[i][31:0]);
        end

        // R7 gate off
        ext_en = 1'b0;
        wr(32'hA5000003);
        fire();
        chk("R7 no pulse when disabled", {31'd0, pulse_active}, 32'd0);
        ext_en = 1'b1;

        // R10 push-pull active-high, width 3
        wr(32'hA8000003);
        chk("R10 pp idle oe/pin", {30'd0, pin_oe, pin_o}, 32'h2);
        fire();
        chk("R7 pulse starts", {31'd0, pulse_active}, 32'd1);
        chk("R10 pp active oe/pin", {30'd0, pin_oe, pin_o}, 32'h3);
        for (int t = 0; t < 3; t++) tick();
        chk("R8 active after W ticks", {31'd0, pulse_active}, 32'd1);
        tick();
        chk("R8 ends after W+1 ticks", {31'd0, pulse_active}, 32'd0);
        chk("R10 pp back idle pin", {31'd0, pin_o}, 32'd0);

        // R9 retrigger
        fire();
        tick(); tick();
        fire();
        for (int t = 0; t < 3; t++) tick();
        chk("R9 still active after reload", {31'd0, pulse_active}, 32'd1);
        tick();
        chk("R9 ends W+1 after reload", {31'd0, pulse_active}, 32'd0);

        // R11 open-drain active-low, width 1
        wr(32'h5A000001);
        wr(32'h8A000001);
        chk("R11 od idle released", {31'd0, pin_oe}, 32'd0);
        fire();
        chk("R11 od drives active low", {30'd0, pin_oe, pin_o}, 32'h2);
        tick(); tick();
        chk("R11 od released after pulse", {31'd0, pin_oe}, 32'd0);

        // R8 width zero
        wr(32'h00000000);
        fire();
        chk("R8 zero width starts", {31'd0, pulse_active}, 32'd1);
        step();
        chk("R8 zero width waits tick", {31'd0, pulse_active}, 32'd1);
        tick();
        chk("R8 zero width one tick", {31'd0, pulse_active}, 32'd0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule